// File: doc/BRIEF.md
# Channel Status and User Data Bank

This block keeps the two 192-bit side-information blocks that ride along with a two-channel digital audio stream: the channel status block and the user data block. Software fills each through six 32-bit shadow words on a small register bus. While transmission is enabled, the block supplies a line encoder with one channel status bit and one user data bit per audio frame, walking through frame positions 0 to 191. It marks frame 0 so the encoder can emit its block-start preamble.

The words that are being sent are a separate active copy. The active copy is loaded from the shadow words only when a new 192-frame block begins. Software can therefore rewrite the shadows at any time during transmission without tearing the block on the wire. Each time the active copy is reloaded at a block boundary, two sticky ready flags are raised. They tell software that the shadows have been consumed and may be refilled. The flags reach an interrupt line through a set/clear enable mask, and a read of the status word clears them.

The per-frame side-information leaves on a valid/ready stream. While transmission is enabled, `out_valid` is high. A frame position advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented bits and the frame-0 marker hold steady, so the encoder may stall for as long as it needs.

Top module: `csub_bank`

## Requirements
- R1: Shadow words are written at byte addresses 0x80+4k (channel status) and 0x50+4k (user data), for k = 0..5. A read of the same address returns the word on `reg_rdata` one cycle after the read strobe. Unmapped addresses read as zero.
- R2: After reset, channel status word 0 holds 0x00000004: bit 2 set marks the stream not copyrighted, and zero in the emphasis bits means no emphasis. Every other shadow word is zero, and the mask and status words are zero.
- R3: Block bit j (0..191) is word j/32, bit j%32. So the lowest block byte of each word sits in bits 7:0, and higher bytes follow upward. At frame position j of a block, `out_cs_bit` and `out_ud_bit` carry bit j of the active channel status and user data copies.
- R4: While `tx_en` is low, `out_valid` is low, the frame position is held at 0, and the active copies follow the shadows. The first block after enabling therefore carries the latest shadow contents.
- R5: While enabled, the frame position advances by one only when `out_valid` and `out_ready` are both high. After position 191 it wraps to 0. `out_first` is high exactly when the position is 0.
- R6: A handshake at position 191 reloads both active copies from the shadows. A shadow write made during a block does not alter the bits still to be sent in that block; it appears in the next block.
- R7: While `out_valid` is high and `out_ready` is low, `out_cs_bit`, `out_ud_bit` and `out_first` stay stable.
- R8: The handshake at position 191 sets status bit 6 (channel status ready) and status bit 7 (user data ready). Both bits stay set until the status word at 0x20 is read.
- R9: A read of the status word at 0x20 returns the flags and then clears them. If a block-boundary set happens in the same cycle as the read, the set wins.
- R10: A write to 0x14 sets every mask bit written as 1. A write to 0x18 clears every mask bit written as 1. The mask reads back at 0x1C. Only bits 6 and 7 are implemented; the others read as zero.
- R11: `irq` is high exactly when some status bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_en | input | 1 | Transmission enable |
| out_valid | output | 1 | Side-information for the current frame is available |
| out_ready | input | 1 | Encoder accepts the current frame's bits |
| out_cs_bit | output | 1 | Channel status bit for the current frame |
| out_ud_bit | output | 1 | User data bit for the current frame |
| out_first | output | 1 | Current frame is position 0 of a block |
| irq | output | 1 | Interrupt request |

## Verification
Read data appears one cycle after the read strobe. The bench drives the strobe on a falling edge and samples `reg_rdata` at the next falling edge.

The stream outputs are a direct function of registered state. The bench samples them shortly after each falling edge, and counts a handshake only when it has itself raised `out_ready` with `out_valid` high.

The ready flags and `irq` change on the rising edge of the position-191 handshake. The bench looks at them only from the following falling edge onward. A status read clears the flags on the same edge that captures them, so the read returns the flags and `irq` drops in the following cycle. Frame-position-dependent expectations come from arithmetic on the bench's own handshake count.

// File: rtl/csub_pkg.sv
package csub_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned RW = 32;

  localparam logic [AW-1:0] ADDR_UD_BASE = 8'h50;
  localparam logic [AW-1:0] ADDR_CS_BASE = 8'h80;
  localparam logic [AW-1:0] ADDR_MSET    = 8'h14;
  localparam logic [AW-1:0] ADDR_MCLR    = 8'h18;
  localparam logic [AW-1:0] ADDR_MASK    = 8'h1C;
  localparam logic [AW-1:0] ADDR_STAT    = 8'h20;

  localparam int unsigned FLAG_CS = 6;
  localparam int unsigned FLAG_UD = 7;

  localparam logic [RW-1:0] FLAG_BITS = (RW'(1) << FLAG_CS) | (RW'(1) << FLAG_UD);
  localparam logic [RW-1:0] CS_WORD0_INIT = 32'h0000_0004;
endpackage

// File: rtl/csub_regfile.sv
module csub_regfile
  import csub_pkg::*;
#(
  parameter int unsigned WORDS = 6,
  localparam int unsigned BLK = WORDS * RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic [RW-1:0] mask_q,
  input  logic [RW-1:0] stat_q,
  output logic [RW-1:0] reg_rdata,
  output logic [BLK-1:0] sh_cs,
  output logic [BLK-1:0] sh_ud
);
  logic [RW-1:0] rd_mux;
  logic [WORDS-1:0] hit_cs, hit_ud;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam logic [AW-1:0] A_CS = ADDR_CS_BASE + AW'(4 * k);
    localparam logic [AW-1:0] A_UD = ADDR_UD_BASE + AW'(4 * k);
    localparam logic [RW-1:0] CS_INIT = (k == 0) ? CS_WORD0_INIT : '0;

    assign hit_cs[k] = (reg_addr == A_CS);
    assign hit_ud[k] = (reg_addr == A_UD);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_cs[k*RW +: RW] <= CS_INIT;
        sh_ud[k*RW +: RW] <= '0;
      end else if (reg_wr) begin
        if (hit_cs[k]) sh_cs[k*RW +: RW] <= reg_wdata;
        if (hit_ud[k]) sh_ud[k*RW +: RW] <= reg_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (hit_cs[k]) rd_mux = sh_cs[k*RW +: RW];
      if (hit_ud[k]) rd_mux = sh_ud[k*RW +: RW];
    end
    if (reg_addr == ADDR_MASK) rd_mux = mask_q;
    if (reg_addr == ADDR_STAT) rd_mux = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/csub_irq.sv
module csub_irq
  import csub_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic          blk_swap,
  output logic [RW-1:0] mask_q,
  output logic [RW-1:0] stat_q,
  output logic          irq
);
  logic set_req, clr_req, stat_rd;

  assign set_req = reg_wr && (reg_addr == ADDR_MSET);
  assign clr_req = reg_wr && (reg_addr == ADDR_MCLR);
  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (set_req) begin
      mask_q <= mask_q | (reg_wdata & FLAG_BITS);
    end else if (clr_req) begin
      mask_q <= mask_q & ~(reg_wdata & FLAG_BITS);
    end
  end

  // set from a block boundary takes priority over the read side effect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (blk_swap) begin
      stat_q <= FLAG_BITS;
    end else if (stat_rd) begin
      stat_q <= '0;
    end
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/csub_seq.sv
module csub_seq
  import csub_pkg::*;
#(
  parameter int unsigned WORDS = 6,
  localparam int unsigned BLK = WORDS * RW,
  localparam int unsigned IW  = $clog2(BLK),
  localparam logic [IW-1:0] LAST = IW'(BLK - 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_en,
  input  logic [BLK-1:0] sh_cs,
  input  logic [BLK-1:0] sh_ud,
  input  logic           out_ready,
  output logic           out_valid,
  output logic           out_cs_bit,
  output logic           out_ud_bit,
  output logic           out_first,
  output logic           blk_swap
);
  logic [IW-1:0]  pos;
  logic [BLK-1:0] act_cs, act_ud;
  logic           fire;

  assign out_valid = tx_en;
  assign fire      = out_valid && out_ready;
  assign blk_swap  = fire && (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      act_cs <= {{(BLK-RW){1'b0}}, CS_WORD0_INIT};
      act_ud <= '0;
    end else if (!tx_en) begin
      pos    <= '0;
      act_cs <= sh_cs;
      act_ud <= sh_ud;
    end else if (fire) begin
      if (pos == LAST) begin
        pos    <= '0;
        act_cs <= sh_cs;
        act_ud <= sh_ud;
      end else begin
        pos <= pos + IW'(1);
      end
    end
  end

  assign out_cs_bit = act_cs[pos];
  assign out_ud_bit = act_ud[pos];
  assign out_first  = (pos == '0);
endmodule

// File: rtl/csub_bank.sv
module csub_bank
  import csub_pkg::*;
#(
  parameter int unsigned WORDS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_cs_bit,
  output logic          out_ud_bit,
  output logic          out_first,
  output logic          irq
);
  localparam int unsigned BLK = WORDS * RW;

  logic [BLK-1:0] sh_cs, sh_ud;
  logic [RW-1:0]  mask_q, stat_q;
  logic           blk_swap;

  csub_regfile #(.WORDS(WORDS)) regs_i (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .mask_q, .stat_q, .reg_rdata, .sh_cs, .sh_ud
  );

  csub_irq irq_i (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .blk_swap, .mask_q, .stat_q, .irq
  );

  csub_seq #(.WORDS(WORDS)) seq_i (
    .clk, .rst_n, .tx_en, .sh_cs, .sh_ud, .out_ready,
    .out_valid, .out_cs_bit, .out_ud_bit, .out_first, .blk_swap
  );
endmodule

// File: rtl/csub_bank_chk.sv
module csub_bank_chk
  import csub_pkg::*;
#(
  parameter int unsigned WORDS = 6,
  localparam int unsigned BLK = WORDS * RW,
  localparam int unsigned IW  = $clog2(BLK)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        tx_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_cs_bit,
  input logic        out_ud_bit,
  input logic        out_first,
  input logic        irq
);
  logic [IW-1:0] n_hs;
  logic hs, hs_last;

  assign hs      = out_valid && out_ready;
  assign hs_last = hs && (n_hs == IW'(BLK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       n_hs <= '0;
    else if (!tx_en)  n_hs <= '0;
    else if (hs_last) n_hs <= '0;
    else if (hs)      n_hs <= n_hs + IW'(1);
  end

  // R4
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !out_valid);

  // R5
  first_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == (n_hs == '0)));

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!tx_en ||
      ($stable(out_cs_bit) && $stable(out_ud_bit) && $stable(out_first))));

  // R9
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_STAT && !hs_last) |=> !irq);

  // R10
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_MCLR && reg_wdata[FLAG_UD] && reg_wdata[FLAG_CS]) |=> !irq);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hs_last || (reg_wr && reg_addr == ADDR_MSET)));
endmodule

bind csub_bank csub_bank_chk #(.WORDS(WORDS)) chk_i (
  .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .tx_en,
  .out_valid, .out_ready, .out_cs_bit, .out_ud_bit, .out_first, .irq
);

// File: tb/csub_bank_tb_top.sv
module csub_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_en = 1'b0, out_ready = 1'b0;
  logic out_valid, out_cs_bit, out_ud_bit, out_first, irq;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  csub_bank dut_i (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .tx_en, .out_valid, .out_ready, .out_cs_bit, .out_ud_bit, .out_first, .irq
  );

  function automatic logic [31:0] cs_pat(int k);
    return 32'hA5C3_0F11 + 32'(k) * 32'h1357_9BDF;
  endfunction
  function automatic logic [31:0] ud_pat(int k);
    return 32'h5A3C_F0EE ^ (32'(k) * 32'h0F0F_1111);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  logic [191:0] got_cs, got_ud;

  task automatic stream(int n, int start, bit bp, output int first_err);
    int got = 0;
    int c = 0;
    first_err = 0;
    while (got < n) begin
      @(negedge clk);
      out_ready = bp ? ((c % 3) != 1) : 1'b1;
      c++;
      #1;
      if (out_valid && out_ready) begin
        got_cs[start + got] = out_cs_bit;
        got_ud[start + got] = out_ud_bit;
        if (out_first !== ((start + got) == 0)) first_err++;
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [191:0] exp_cs, exp_ud;
    int fe;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(8'h80, d); chk("R2 cs word0", d, 32'h4);
    for (int k = 1; k < 6; k++) begin rd(8'h80 + 8'(4*k), d); chk("R2 cs word", d, 0); end
    for (int k = 0; k < 6; k++) begin rd(8'h50 + 8'(4*k), d); chk("R2 ud word", d, 0); end
    rd(8'h1C, d); chk("R2 mask", d, 0);
    rd(8'h20, d); chk("R2 status", d, 0);
    chk("R4 valid idle", 32'(out_valid), 0);
    chk("R11 irq reset", 32'(irq), 0);

    // R1 shadow write/readback sweep
    for (int k = 0; k < 6; k++) begin
      wr(8'h80 + 8'(4*k), cs_pat(k));
      wr(8'h50 + 8'(4*k), ud_pat(k));
    end
    for (int k = 0; k < 6; k++) begin
      rd(8'h80 + 8'(4*k), d); chk("R1 cs readback", d, cs_pat(k));
      rd(8'h50 + 8'(4*k), d); chk("R1 ud readback", d, ud_pat(k));
    end
    rd(8'h68, d); chk("R1 unmapped", d, 0);
    rd(8'h98, d); chk("R1 unmapped", d, 0);

    // R10 mask set/clear
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h1C, d); chk("R10 set all", d, 32'hC0);
    wr(8'h18, 32'h40);        rd(8'h1C, d); chk("R10 clear bit6", d, 32'h80);
    wr(8'h14, 32'h40);        rd(8'h1C, d); chk("R10 set bit6", d, 32'hC0);

    for (int j = 0; j < 192; j++) begin
      exp_cs[j] = cs_pat(j / 32)[j % 32];
      exp_ud[j] = ud_pat(j / 32)[j % 32];
    end

    // R3/R4/R5/R6 first block, shadow word 5 rewritten mid-block
    @(negedge clk); tx_en = 1'b1;
    #1 chk("R4 valid on enable", 32'(out_valid), 1);
    stream(50, 0, 1'b0, fe);
    chk("R5 first marker a", fe, 0);
    d = out_cs_bit;
    repeat (3) @(negedge clk);
    chk("R7 stall hold", 32'(out_cs_bit), d);
    wr(8'h94, 32'hDEAD_BEEF);
    wr(8'h64, 32'h1234_5678);
    chk("R11 irq before wrap", 32'(irq), 0);
    stream(142, 50, 1'b0, fe);
    chk("R5 first marker b", fe, 0);
    chk("R3 cs block lo", got_cs[95:0], exp_cs[95:0]);
    chk("R6 cs block hi kept", got_cs[191:160], exp_cs[191:160]);
    chk("R6 ud block hi kept", got_ud[191:160], exp_ud[191:160]);
    chk("R3 ud block mid", got_ud[159:128], exp_ud[159:128]);
    chk("R5 wrap to first", 32'(out_first), 1);

    // R8/R9/R11 flags after boundary
    chk("R11 irq after wrap", 32'(irq), 1);
    rd(8'h20, d); chk("R8 flags set", d, 32'hC0);
    #1 chk("R9 irq after read", 32'(irq), 0);
    rd(8'h20, d); chk("R9 cleared", d, 0);

    // R6 second block with back-pressure carries new words; mask off
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R10 clear all", d, 0);
    exp_cs[191:160] = 32'hDEAD_BEEF;
    exp_ud[191:160] = 32'h1234_5678;
    stream(192, 0, 1'b1, fe);
    chk("R5 first marker bp", fe, 0);
    chk("R6 cs new word", got_cs[191:160], exp_cs[191:160]);
    chk("R6 ud new word", got_ud[191:160], exp_ud[191:160]);
    chk("R3 cs bp low", got_cs[159:128], exp_cs[159:128]);
    chk("R11 masked irq", 32'(irq), 0);
    rd(8'h20, d); chk("R8 flags masked", d, 32'hC0);

    // R4 idle write loads immediately on next enable
    @(negedge clk); tx_en = 1'b0;
    #1 chk("R4 valid off", 32'(out_valid), 0);
    wr(8'h80, 32'h0F0F_3C3C);
    wr(8'h50, 32'h8001_7FFE);
    @(negedge clk); tx_en = 1'b1;
    stream(32, 0, 1'b0, fe);
    chk("R4 cs idle load", got_cs[31:0], 32'h0F0F_3C3C);
    chk("R4 ud idle load", got_ud[31:0], 32'h8001_7FFE);
    chk("R5 first marker c", fe, 0);
    @(negedge clk); tx_en = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule